// File: doc/BRIEF.md
# Fractional-Divide PWM Time Base

This block is the shared time base behind a group of PWM channels. It takes one of two tick sources, both given as single-cycle enable pulses in the system clock domain. It divides that tick stream by a fixed-point ratio that has an integer part and an 8-bit fraction. The divided ticks step a counter. The counter runs from zero up to a top value of two to the power of a resolution setting, minus one, then returns to zero. The channels compare against the count, and the one-cycle wrap strobe marks the start of each PWM period.

Software loads a new divisor and resolution by presenting them on the configuration inputs together with a one-cycle update request. The values are held in a staging register and a busy flag is raised. The staged values take effect only at the next counter wrap, so the period in progress always completes with the settings it started with. The busy flag drops by itself at that point. A pause input freezes the time base. A clear input holds it at zero.

Top module: `ptmr_top`

## Requirements
- R1: After reset the count is 0, the wrap strobe is 0 and the busy flag is 0. The active divisor is 1.0 and the active resolution is 0, so the counter wraps on every selected tick.
- R2: With the source select at 0 only slow_tick advances the time base, and with it at 1 only ref_tick does. A tick on the unselected source changes neither the count nor the wrap strobe.
- R3: The integer part of the divisor is div_cfg[17:8], and the divided tick comes every N selected ticks. An integer part of 0 acts as 1.
- R4: The fraction div_cfg[7:0] is added into an 8-bit accumulator on each divided tick. A period in which that addition carries out lasts N+1 selected ticks, so eight periods at divisor 2.5 take 20 ticks.
- R5: The count steps by one per divided tick from 0 to 2^res-1 and then returns to 0. A resolution above the counter width CNT_W acts as CNT_W.
- R6: The wrap strobe is high for exactly the one cycle in which the count has just returned to 0 from its top value.
- R7: While pause is high and clear is low, the count, the wrap strobe and the divider phase do not advance.
- R8: While cnt_clr is high, the count reads 0, no wrap is signalled, and the divider phase and fraction accumulator restart from 0. Clear has priority over pause.
- R9: An update request captures div_cfg and res_cfg and sets upd_busy in the next cycle. The captured values become active at the next wrap, and upd_busy clears in that same cycle. At any other time the configuration inputs have no effect.
- R10: If a request arrives in the same cycle that a wrap applies an earlier request, the earlier values are applied, the new values are staged, and upd_busy stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Tick source 0, single-cycle enable |
| ref_tick | input | 1 | Tick source 1, single-cycle enable |
| src_sel | input | 1 | Tick source select, 0 slow, 1 reference |
| div_cfg | input | DIV_W (18) | Divisor to stage, low FRAC_W bits fractional |
| res_cfg | input | RES_W (5) | Counter resolution to stage |
| upd_req | input | 1 | One-cycle request to stage the configuration |
| pause | input | 1 | Freeze the time base |
| cnt_clr | input | 1 | Hold the time base at zero |
| count | output | CNT_W (20) | Current count |
| wrap | output | 1 | One-cycle strobe on return to zero |
| upd_busy | output | 1 | Staged configuration waiting for a wrap |

## Verification
A wrong fraction accumulator or divider phase does not change the count sequence. It shows up as wrap intervals that are one selected tick too long or too short, and the error appears within a few periods at fractions such as one half. A staging fault appears at the first wrap after a request: the following interval has the old length, or upd_busy falls on a cycle without a wrap. A bad resolution clamp shows up as the count going past its top value before wrap is seen, and that is visible within a single period.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  typedef enum logic {
    SRC_SLOW = 1'b0,
    SRC_REF  = 1'b1
  } ptmr_src_e;
endpackage

// File: rtl/ptmr_frac_div.sv
module ptmr_frac_div #(
  parameter int DIV_W  = 18,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_tick,
  input  logic             run,
  input  logic             clr,
  input  logic [DIV_W-1:0] div_val,
  output logic             div_tick
);
  localparam int INT_W = DIV_W - FRAC_W;
  localparam int PH_W  = INT_W + 1;

  logic [PH_W-1:0]   phase_q, phase_d, n_eff, target;
  logic [FRAC_W-1:0] acc_q, acc_d, acc_sum;
  logic [INT_W-1:0]  int_part;
  logic [FRAC_W-1:0] frac_part;
  logic              carry, adv, hit, en;

  assign int_part  = div_val[DIV_W-1:FRAC_W];
  assign frac_part = div_val[FRAC_W-1:0];

  always_comb begin
    n_eff            = (int_part == '0) ? PH_W'(1) : {1'b0, int_part};
    {carry, acc_sum} = {1'b0, acc_q} + {1'b0, frac_part};
    target           = n_eff + PH_W'(carry);
    hit              = (phase_q + PH_W'(1)) == target;
    adv              = src_tick & run;
    div_tick         = adv & hit;
    en               = adv | clr;
    phase_d          = phase_q;
    acc_d            = acc_q;
    if (clr) begin
      phase_d = '0;
      acc_d   = '0;
    end else if (adv) begin
      if (hit) begin
        phase_d = '0;
        acc_d   = acc_sum;
      end else begin
        phase_d = phase_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
    end else if (en) begin
      phase_q <= phase_d;
      acc_q   <= acc_d;
    end
  end
endmodule

// File: rtl/ptmr_range_cnt.sv
module ptmr_range_cnt #(
  parameter int CNT_W = 20,
  parameter int RES_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [RES_W-1:0] res_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             wrap_now
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap_q, wrap_d;
  logic [RES_W-1:0] res_eff;
  logic [CNT_W:0]   top_val;
  logic             at_top;

  always_comb begin
    res_eff  = (int'(res_val) > CNT_W) ? RES_W'(CNT_W) : res_val;
    top_val  = ((CNT_W+1)'(1) << res_eff) - (CNT_W+1)'(1);
    at_top   = {1'b0, cnt_q} == top_val;
    wrap_now = step & at_top & ~clr;
    cnt_d    = cnt_q;
    wrap_d   = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (step) begin
      if (at_top) begin
        cnt_d  = '0;
        wrap_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign count = cnt_q;
  assign wrap  = wrap_q;
endmodule

// File: rtl/ptmr_cfg_stage.sv
module ptmr_cfg_stage #(
  parameter int               DIV_W   = 18,
  parameter int               RES_W   = 5,
  parameter logic [DIV_W-1:0] RST_DIV = '0,
  parameter logic [RES_W-1:0] RST_RES = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_req,
  input  logic [DIV_W-1:0] div_in,
  input  logic [RES_W-1:0] res_in,
  input  logic             wrap_now,
  output logic [DIV_W-1:0] act_div,
  output logic [RES_W-1:0] act_res,
  output logic             busy
);
  logic [DIV_W-1:0] act_div_q, stg_div_q;
  logic [RES_W-1:0] act_res_q, stg_res_q;
  logic             busy_q, busy_d, apply;

  always_comb begin
    apply  = wrap_now & busy_q;
    busy_d = busy_q;
    if (apply)   busy_d = 1'b0;
    if (upd_req) busy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div_q <= RST_DIV;
      act_res_q <= RST_RES;
      stg_div_q <= RST_DIV;
      stg_res_q <= RST_RES;
      busy_q    <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (apply) begin
        act_div_q <= stg_div_q;
        act_res_q <= stg_res_q;
      end
      if (upd_req) begin
        stg_div_q <= div_in;
        stg_res_q <= res_in;
      end
    end
  end

  assign act_div = act_div_q;
  assign act_res = act_res_q;
  assign busy    = busy_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top #(
  parameter int DIV_W  = 18,
  parameter int FRAC_W = 8,
  parameter int RES_W  = 5,
  parameter int CNT_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             ref_tick,
  input  logic             src_sel,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [RES_W-1:0] res_cfg,
  input  logic             upd_req,
  input  logic             pause,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             upd_busy
);
  import ptmr_pkg::*;

  localparam logic [DIV_W-1:0] UNITY_DIV = DIV_W'(1) << FRAC_W;

  logic             sel_tick, run, div_tick, wrap_now;
  logic [DIV_W-1:0] act_div;
  logic [RES_W-1:0] act_res;

  assign sel_tick = (ptmr_src_e'(src_sel) == SRC_REF) ? ref_tick : slow_tick;
  assign run      = ~pause & ~cnt_clr;

  ptmr_cfg_stage #(
    .DIV_W  (DIV_W),
    .RES_W  (RES_W),
    .RST_DIV(UNITY_DIV),
    .RST_RES('0)
  ) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_req (upd_req),
    .div_in  (div_cfg),
    .res_in  (res_cfg),
    .wrap_now(wrap_now),
    .act_div (act_div),
    .act_res (act_res),
    .busy    (upd_busy)
  );

  ptmr_frac_div #(
    .DIV_W (DIV_W),
    .FRAC_W(FRAC_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_tick(sel_tick),
    .run     (run),
    .clr     (cnt_clr),
    .div_val (act_div),
    .div_tick(div_tick)
  );

  ptmr_range_cnt #(
    .CNT_W(CNT_W),
    .RES_W(RES_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (div_tick),
    .clr     (cnt_clr),
    .res_val (act_res),
    .count   (count),
    .wrap    (wrap),
    .wrap_now(wrap_now)
  );
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slow_tick,
  input logic             ref_tick,
  input logic             src_sel,
  input logic             upd_req,
  input logic             pause,
  input logic             cnt_clr,
  input logic [CNT_W-1:0] count,
  input logic             wrap,
  input logic             upd_busy
);
  logic chosen;
  assign chosen = src_sel ? ref_tick : slow_tick;

  // R2
  idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chosen && !cnt_clr) |=> ($stable(count) && !wrap));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == CNT_W'($past(count) + CNT_W'(1))) || (count == '0)));

  // R6
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (count == '0));

  // R7
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !cnt_clr) |=> ($stable(count) && !wrap));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> ((count == '0) && !wrap));

  // R9
  req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> upd_busy);

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(upd_busy) |-> wrap);
endmodule

bind ptmr_top ptmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .slow_tick(slow_tick),
  .ref_tick (ref_tick),
  .src_sel  (src_sel),
  .upd_req  (upd_req),
  .pause    (pause),
  .cnt_clr  (cnt_clr),
  .count    (count),
  .wrap     (wrap),
  .upd_busy (upd_busy)
);

// File: tb/ptmr_top_tb.sv
`timescale 1ns/1ps
module ptmr_top_tb;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_tick = 1'b0, ref_tick = 1'b0, src_sel = 1'b0;
  logic [17:0]   div_cfg = '0;
  logic [4:0]    res_cfg = '0;
  logic          upd_req = 1'b0, pause = 1'b0, cnt_clr = 1'b0;
  logic [CW-1:0] count;
  logic          wrap, upd_busy;

  int checks = 0, fails = 0, tcyc = 0;
  int slow_per = 0, ref_per = 0;
  bit chk_on = 0, done = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  ptmr_top #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ref_tick(ref_tick),
    .src_sel(src_sel), .div_cfg(div_cfg), .res_cfg(res_cfg), .upd_req(upd_req),
    .pause(pause), .cnt_clr(cnt_clr), .count(count), .wrap(wrap), .upd_busy(upd_busy)
  );

  // behavioural reference
  int m_cnt, m_ph, m_acc, m_div, m_res, s_div, s_res, m_busy, m_wrap;
  always @(posedge clk) begin
    int src, n, f, tgt, re, nw;
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_acc = 0; m_div = 256; m_res = 0;
      s_div = 256; s_res = 0; m_busy = 0; m_wrap = 0;
    end else begin
      src = src_sel ? int'(ref_tick) : int'(slow_tick);
      nw = 0;
      if (cnt_clr) begin
        m_cnt = 0; m_ph = 0; m_acc = 0;
      end else if (!pause && src == 1) begin
        n = m_div / 256; if (n == 0) n = 1;
        f = m_div % 256;
        tgt = n + ((m_acc + f >= 256) ? 1 : 0);
        if (m_ph + 1 == tgt) begin
          m_ph = 0; m_acc = (m_acc + f) % 256;
          re = (m_res > CW) ? CW : m_res;
          if (m_cnt == (1 << re) - 1) begin m_cnt = 0; nw = 1; end
          else m_cnt = m_cnt + 1;
        end else m_ph = m_ph + 1;
      end
      if (nw == 1 && m_busy == 1) begin m_div = s_div; m_res = s_res; m_busy = 0; end
      if (upd_req) begin s_div = int'(div_cfg); s_res = int'(res_cfg); m_busy = 1; end
      m_wrap = nw;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_on && !done) begin
      checks++;
      if (int'(count) != m_cnt || int'(wrap) != m_wrap || int'(upd_busy) != m_busy) begin
        fails++;
        $display("FAIL %s model: count=%0d wrap=%0d busy=%0d expected %0d %0d %0d",
                 tag, count, wrap, upd_busy, m_cnt, m_wrap, m_busy);
      end
    end
  end

  always @(posedge clk) begin
    tcyc++;
    if (tcyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", tcyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic gen(int per);
    if (per == 0) return 1'b0;
    if (per < 0) return logic'($urandom % 2);
    return logic'((tcyc % per) == 0);
  endfunction

  task automatic step();
    @(posedge clk); #2;
    slow_tick = gen(slow_per);
    ref_tick  = gen(ref_per);
  endtask

  task automatic check(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic request(int d, int r);
    div_cfg = 18'(d); res_cfg = 5'(r); upd_req = 1'b1;
    step();
    upd_req = 1'b0;
    check("R9 busy after request", int'(upd_busy), 1);
  endtask

  task automatic next_wrap();
    for (int i = 0; i < 2000; i++) begin
      step();
      if (wrap) return;
    end
  endtask

  task automatic interval(output int iv);
    next_wrap();
    iv = 0;
    for (int i = 0; i < 2000; i++) begin
      step(); iv++;
      if (wrap) return;
    end
  endtask

  int iv, hold;

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    chk_on = 1;
    step();
    tag = "R1";
    check("R1 reset count", int'(count), 0);
    check("R1 reset wrap", int'(wrap), 0);
    check("R1 reset busy", int'(upd_busy), 0);
    slow_per = 1;
    step(); step();
    check("R1 default res wraps every tick", int'(wrap), 1);

    tag = "R9";
    request(256, 3);
    next_wrap();
    check("R9 busy cleared at wrap", int'(upd_busy), 0);
    div_cfg = 18'h3ff; res_cfg = 5'd1;
    interval(iv);
    check("R9 config inputs ignored without request", iv, 8);

    tag = "R6";
    next_wrap(); step();
    check("R6 wrap lasts one cycle", int'(wrap), 0);
    check("R6 count after wrap", int'(count), 1);

    tag = "R4";
    request(18'h280, 3);
    next_wrap();
    interval(iv);
    check("R4 eight periods at 2.5", iv, 20);

    tag = "R3";
    request(18'h000, 2);
    next_wrap();
    interval(iv);
    check("R3 zero integer acts as one", iv, 4);
    request(18'h300, 1);
    next_wrap();
    interval(iv);
    check("R3 integer divide by 3", iv, 6);

    tag = "R5";
    request(256, 31);
    next_wrap();
    interval(iv);
    check("R5 resolution clamp", iv, 64);

    tag = "R2";
    request(256, 2);
    next_wrap();
    src_sel = 1'b1; ref_per = 2;
    interval(iv);
    check("R2 reference source every 2", iv, 8);
    ref_per = 0;
    step(); hold = int'(count);
    repeat (10) step();
    check("R2 unselected ticks ignored", int'(count), hold);
    src_sel = 1'b0;

    tag = "R7";
    pause = 1'b1;
    step(); hold = int'(count);
    repeat (12) step();
    check("R7 pause holds count", int'(count), hold);
    pause = 1'b0;
    repeat (5) step();

    tag = "R8";
    cnt_clr = 1'b1; pause = 1'b1;
    step(); step();
    check("R8 clear forces zero", int'(count), 0);
    cnt_clr = 1'b0; pause = 1'b0;
    interval(iv);
    check("R8 period intact after clear", iv, 4);

    tag = "R10";
    request(256, 0);
    next_wrap();
    request(256, 0);
    request(256, 3);
    check("R10 busy kept by overlapping request", int'(upd_busy), 1);
    next_wrap();
    interval(iv);
    check("R10 later request applied", iv, 8);

    tag = "R4";
    slow_per = -1; ref_per = -1;
    for (int k = 0; k < 60; k++) begin
      if (k % 10 == 0) begin
        div_cfg = 18'($urandom % 1024); res_cfg = 5'($urandom % 6); upd_req = 1'b1;
      end
      src_sel = logic'($urandom % 2);
      pause   = logic'(($urandom % 8) == 0);
      cnt_clr = logic'(($urandom % 25) == 0);
      step();
      upd_req = 1'b0;
      repeat (30) step();
    end
    pause = 1'b0; cnt_clr = 1'b0;
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule